// File: doc/BRIEF.md
# Timer-Aware Shutdown Arbiter

When the processor asks to power down, this block decides whether it may actually enter its low-power state. Two timers can each veto the request. A timer vetoes when it is armed for wake-up and its counter has already reached the half-way mark, which is its most significant bit. A veto consumes that timer's wake-enable through a one-cycle clear strobe. The request is also refused while any bit of the pending interrupt word is nonzero.

A power-off request is a single-cycle strobe. The timer and interrupt inputs are sampled on the edge that accepts the strobe, and the verdict is registered on the following edge. If every condition allows entry, the shutdown state goes high, and a one-cycle interrupt-exit pulse fires with it so the execution loop can stop. The shutdown state then holds until an external wake input clears it. The timers' own counting and the sequence after wake-up belong to other blocks.

Top module: `sleep_gate`

## Requirements
- R1: After reset, `sleep_o`, `exit_pulse_o`, `t1_wke_clr_o` and `t2_wke_clr_o` are all 0.
- R2: If `t1_wke_i` is 1 and bit 3 of `t1_val_i` is 1 on the edge that accepts a request, `t1_wke_clr_o` is 1 for exactly the cycle after the next edge, and shutdown is not entered. Only the values present on the accepting edge count.
- R3: If `t2_wke_i` is 1 and bit 31 of `t2_val_i` is 1 on the accepting edge, `t2_wke_clr_o` pulses with the same timing as in R2, and shutdown is not entered.
- R4: Both timers are evaluated on every request, so both clear strobes can pulse together in the same cycle.
- R5: A timer whose wake-enable is 0, or whose most significant bit is 0, produces no clear strobe and does not block entry.
- R6: Shutdown is entered only when neither timer vetoes and `irq_in_i` is all zeros on the accepting edge. A nonzero interrupt word blocks entry but does not suppress the timers' clear strobes.
- R7: Entry raises `sleep_o` and a one-cycle `exit_pulse_o` on the same edge, which is the second edge after the request is driven. `exit_pulse_o` fires only while `sleep_o` is rising.
- R8: `sleep_o` stays 1 until `wake_i` is seen on a clock edge, and it clears on that edge. If an entry and `wake_i` fall on the same edge, the entry wins.
- R9: A request accepted while `sleep_o` is 1 is ignored. It produces no clear strobe and no exit pulse, and `sleep_o` stays 1.
- R10: `wake_i` while `sleep_o` is 0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| off_req_i | input | 1 | Power-off request strobe |
| t1_wke_i | input | 1 | Timer 1 wake-enable bit |
| t1_val_i | input | T1_W (4) | Timer 1 current value |
| t2_wke_i | input | 1 | Timer 2 wake-enable bit |
| t2_val_i | input | T2_W (32) | Timer 2 current value |
| irq_in_i | input | IRQ_W (5) | Pending interrupt input word |
| wake_i | input | 1 | External wake, clears the shutdown state |
| sleep_o | output | 1 | Shutdown state |
| exit_pulse_o | output | 1 | One-cycle interrupt-exit pulse on entry |
| t1_wke_clr_o | output | 1 | One-cycle clear strobe for timer 1 wake-enable |
| t2_wke_clr_o | output | 1 | One-cycle clear strobe for timer 2 wake-enable |

## Verification
Every verdict output is due on the second rising edge after the request is driven: the first edge takes a snapshot and the second registers the result. The bench therefore drives on a falling edge and checks the outputs at the falling edges that follow. It expects all zeros after the first edge, the verdict after the second, and the clear strobes and exit pulse gone after the third. Between the two edges the bench drives inverted timer and interrupt values, which shows that only the snapshot counts. Wake takes effect on the single edge where it is sampled, so the bench checks `sleep_o` at the next falling edge.

// File: rtl/sleep_gate_pkg.sv
package sleep_gate_pkg;

  // verdict of one evaluated power-off request
  typedef struct packed {
    logic clr_t1;
    logic clr_t2;
    logic enter;
  } verdict_t;

  // snapshot taken on the accepting edge
  typedef struct packed {
    logic hit_t1;
    logic hit_t2;
    logic irq_busy;
  } snap_t;

endpackage

// File: rtl/sleep_gate_probe.sv
// Decides whether one timer vetoes shutdown: armed and past half-range.
module sleep_gate_probe #(
  parameter int W = 4
) (
  input  logic         wke_i,
  input  logic [W-1:0] val_i,
  output logic         hit_o
);

  assign hit_o = wke_i & val_i[W-1];

  generate
    if (W > 1) begin : g_low
      logic unused_low;
      assign unused_low = ^val_i[W-2:0];
    end
  endgenerate

endmodule

// File: rtl/sleep_gate_verdict.sv
// Snapshots the request conditions, then registers the verdict one edge later.
module sleep_gate_verdict
  import sleep_gate_pkg::*;
#(
  parameter int IRQ_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             sleep_i,
  input  logic             hit_t1_i,
  input  logic             hit_t2_i,
  input  logic [IRQ_W-1:0] irq_i,
  output verdict_t         verdict_o,
  output verdict_t         verdict_nxt_o
);

  logic     accept;
  logic     pend_q, pend_d;
  snap_t    snap_q, snap_d;
  verdict_t vrd_q, vrd_d;

  // next-state
  always_comb begin
    accept          = req_i & ~sleep_i;
    pend_d          = accept;
    snap_d          = snap_q;
    if (accept) begin
      snap_d.hit_t1   = hit_t1_i;
      snap_d.hit_t2   = hit_t2_i;
      snap_d.irq_busy = |irq_i;
    end
    vrd_d.clr_t1 = pend_q & snap_q.hit_t1;
    vrd_d.clr_t2 = pend_q & snap_q.hit_t2;
    vrd_d.enter  = pend_q & ~sleep_i & ~snap_q.hit_t1 & ~snap_q.hit_t2
                   & ~snap_q.irq_busy;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      snap_q <= '0;
      vrd_q  <= '0;
    end else begin
      pend_q <= pend_d;
      snap_q <= snap_d;
      vrd_q  <= vrd_d;
    end
  end

  assign verdict_o     = vrd_q;
  assign verdict_nxt_o = vrd_d;

  // R6: a busy interrupt word on the accepting edge blocks entry
  a_r6_irq_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !sleep_i && (|irq_i)) |=> ##1 !vrd_q.enter);

  // R9: requests while asleep produce nothing
  a_r9_ignored_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && sleep_i) |=> ##1 !(vrd_q.clr_t1 || vrd_q.clr_t2 || vrd_q.enter));

  // R6: a timer veto and an entry never coincide
  a_r6_veto_excludes: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd_q.clr_t1 || vrd_q.clr_t2) |-> !vrd_q.enter);

endmodule

// File: rtl/sleep_gate_state.sv
// Holds the shutdown state: set by entry, cleared by external wake.
module sleep_gate_state (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_i,
  input  logic wake_i,
  output logic sleep_o
);

  logic sleep_q, sleep_d;

  always_comb begin
    sleep_d = sleep_q;
    if (enter_i)     sleep_d = 1'b1;
    else if (wake_i) sleep_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sleep_q <= 1'b0;
    else        sleep_q <= sleep_d;
  end

  assign sleep_o = sleep_q;

  // R8: shutdown holds without a wake
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && !wake_i) |=> sleep_q);

  // R8: wake without entry clears the state
  a_r8_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_i && !enter_i) |=> !sleep_q);

endmodule

// File: rtl/sleep_gate.sv
module sleep_gate
  import sleep_gate_pkg::*;
#(
  parameter int T1_W  = 4,
  parameter int T2_W  = 32,
  parameter int IRQ_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             off_req_i,
  input  logic             t1_wke_i,
  input  logic [T1_W-1:0]  t1_val_i,
  input  logic             t2_wke_i,
  input  logic [T2_W-1:0]  t2_val_i,
  input  logic [IRQ_W-1:0] irq_in_i,
  input  logic             wake_i,
  output logic             sleep_o,
  output logic             exit_pulse_o,
  output logic             t1_wke_clr_o,
  output logic             t2_wke_clr_o
);

  logic     hit_t1, hit_t2;
  verdict_t vrd, vrd_nxt;
  logic     sleep_s;

  sleep_gate_probe #(.W(T1_W)) u_probe_t1 (
    .wke_i (t1_wke_i),
    .val_i (t1_val_i),
    .hit_o (hit_t1)
  );

  sleep_gate_probe #(.W(T2_W)) u_probe_t2 (
    .wke_i (t2_wke_i),
    .val_i (t2_val_i),
    .hit_o (hit_t2)
  );

  sleep_gate_verdict #(.IRQ_W(IRQ_W)) u_verdict (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (off_req_i),
    .sleep_i       (sleep_s),
    .hit_t1_i      (hit_t1),
    .hit_t2_i      (hit_t2),
    .irq_i         (irq_in_i),
    .verdict_o     (vrd),
    .verdict_nxt_o (vrd_nxt)
  );

  sleep_gate_state u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .enter_i (vrd_nxt.enter),
    .wake_i  (wake_i),
    .sleep_o (sleep_s)
  );

  assign sleep_o      = sleep_s;
  assign exit_pulse_o = vrd.enter;
  assign t1_wke_clr_o = vrd.clr_t1;
  assign t2_wke_clr_o = vrd.clr_t2;

  // R2: armed timer 1 past half-range yields its clear strobe
  a_r2_t1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (off_req_i && !sleep_s && hit_t1) |=> ##1 t1_wke_clr_o);

  // R3: armed timer 2 past half-range yields its clear strobe
  a_r3_t2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (off_req_i && !sleep_s && hit_t2) |=> ##1 t2_wke_clr_o);

  // R7: exit pulse only while the shutdown state rises
  a_r7_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse_o |-> (sleep_o && !$past(sleep_o)));

  // R7: exit pulse lasts a single cycle
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse_o |=> !exit_pulse_o);

  // R5: a clear strobe needs a request two edges earlier
  a_r5_clear_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_wke_clr_o || t2_wke_clr_o) |-> $past(off_req_i, 2));

endmodule

// File: tb/sleep_gate_bench.sv
module sleep_gate_bench;

  localparam int T1_W  = 4;
  localparam int T2_W  = 32;
  localparam int IRQ_W = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             off_req_i;
  logic             t1_wke_i;
  logic [T1_W-1:0]  t1_val_i;
  logic             t2_wke_i;
  logic [T2_W-1:0]  t2_val_i;
  logic [IRQ_W-1:0] irq_in_i;
  logic             wake_i;
  logic             sleep_o, exit_pulse_o, t1_wke_clr_o, t2_wke_clr_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sleep_gate #(.T1_W(T1_W), .T2_W(T2_W), .IRQ_W(IRQ_W)) u_sleep_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .off_req_i    (off_req_i),
    .t1_wke_i     (t1_wke_i),
    .t1_val_i     (t1_val_i),
    .t2_wke_i     (t2_wke_i),
    .t2_val_i     (t2_val_i),
    .irq_in_i     (irq_in_i),
    .wake_i       (wake_i),
    .sleep_o      (sleep_o),
    .exit_pulse_o (exit_pulse_o),
    .t1_wke_clr_o (t1_wke_clr_o),
    .t2_wke_clr_o (t2_wke_clr_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one request with the given snapshot; returns whether entry was expected
  task automatic run_req(input logic w1, input logic [T1_W-1:0] v1,
                         input logic w2, input logic [T2_W-1:0] v2,
                         input logic [IRQ_W-1:0] irq, output logic ent);
    logic h1, h2;
    h1  = w1 & v1[T1_W-1];
    h2  = w2 & v2[T2_W-1];
    ent = !h1 && !h2 && (irq == '0);
    @(negedge clk);
    off_req_i = 1'b1;
    t1_wke_i = w1; t1_val_i = v1; t2_wke_i = w2; t2_val_i = v2; irq_in_i = irq;
    @(negedge clk);  // accepting edge passed
    off_req_i = 1'b0;
    t1_wke_i = ~w1; t1_val_i = ~v1; t2_wke_i = ~w2; t2_val_i = ~v2; irq_in_i = ~irq;
    check("R7 no early exit pulse", exit_pulse_o, 1'b0);
    check("R2 no early t1 clear", t1_wke_clr_o, 1'b0);
    check("R3 no early t2 clear", t2_wke_clr_o, 1'b0);
    @(negedge clk);  // verdict edge passed
    check("R2 t1 clear strobe", t1_wke_clr_o, h1);
    check("R3 t2 clear strobe", t2_wke_clr_o, h2);
    check("R6 exit pulse on entry", exit_pulse_o, ent);
    check("R7 sleep on entry", sleep_o, ent);
    @(negedge clk);
    check("R2 t1 strobe one cycle", t1_wke_clr_o, 1'b0);
    check("R3 t2 strobe one cycle", t2_wke_clr_o, 1'b0);
    check("R7 exit pulse one cycle", exit_pulse_o, 1'b0);
    check("R8 sleep held", sleep_o, ent);
  endtask

  task automatic do_wake();
    wake_i = 1'b1;
    @(negedge clk);
    wake_i = 1'b0;
    check("R8 wake clears sleep", sleep_o, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic ent;
    logic [T2_W-1:0] t2p [4];
    logic [IRQ_W-1:0] irp [4];
    t2p[0] = 32'h0000_0000; t2p[1] = 32'h8000_0000;
    t2p[2] = 32'h7FFF_FFFF; t2p[3] = 32'hFFFF_FFFF;
    irp[0] = 5'h00; irp[1] = 5'h01; irp[2] = 5'h10; irp[3] = 5'h1F;
    rst_n = 1'b0; off_req_i = 1'b0; t1_wke_i = 1'b0; t1_val_i = '0;
    t2_wke_i = 1'b0; t2_val_i = '0; irq_in_i = '0; wake_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sleep after reset", sleep_o, 1'b0);
    check("R1 exit after reset", exit_pulse_o, 1'b0);
    check("R1 t1 clear after reset", t1_wke_clr_o, 1'b0);
    check("R1 t2 clear after reset", t2_wke_clr_o, 1'b0);

    // R2..R7 sweep (R4 both strobes, R5 disarmed or low MSB)
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++)
          for (int d = 0; d < 4; d++)
            for (int e = 0; e < 4; e++) begin
              run_req(a[0], b[3:0], c[0], t2p[d], irp[e], ent);
              if (ent) do_wake();
            end

    // R8 hold for many cycles, then wake
    run_req(1'b0, 4'hF, 1'b0, 32'hFFFF_FFFF, 5'h0, ent);
    repeat (20) @(negedge clk);
    check("R8 sleep held long", sleep_o, 1'b1);

    // R9 request while asleep, with both timers vetoing
    @(negedge clk);
    off_req_i = 1'b1; t1_wke_i = 1'b1; t1_val_i = 4'h8;
    t2_wke_i = 1'b1; t2_val_i = 32'h8000_0000; irq_in_i = '0;
    @(negedge clk);
    off_req_i = 1'b0;
    @(negedge clk);
    check("R9 no t1 clear asleep", t1_wke_clr_o, 1'b0);
    check("R9 no t2 clear asleep", t2_wke_clr_o, 1'b0);
    check("R9 no exit asleep", exit_pulse_o, 1'b0);
    check("R9 sleep kept", sleep_o, 1'b1);
    do_wake();

    // R10 wake while awake
    wake_i = 1'b1;
    @(negedge clk);
    wake_i = 1'b0;
    check("R10 wake awake sleep", sleep_o, 1'b0);
    check("R10 wake awake exit", exit_pulse_o, 1'b0);
    check("R10 wake awake t1", t1_wke_clr_o, 1'b0);

    // R8 entry and wake on the same edge: entry wins
    @(negedge clk);
    off_req_i = 1'b1; t1_wke_i = 1'b0; t2_wke_i = 1'b0; irq_in_i = '0;
    @(negedge clk);
    off_req_i = 1'b0; wake_i = 1'b1;
    @(negedge clk);
    wake_i = 1'b0;
    check("R8 entry beats wake", sleep_o, 1'b1);
    check("R7 exit with contested entry", exit_pulse_o, 1'b1);
    @(negedge clk);
    check("R8 contested entry held", sleep_o, 1'b1);
    do_wake();

    report();
  end

endmodule